// File: doc/BRIEF.md
# Debug-Aware Low-Power Mode Controller

This block sequences the power modes of a small system and decides, at each entry into a deep stop mode, whether the core fast clock must keep running for an attached debugger. It tracks six modes: two run modes (full speed and reduced power), two wait modes that pair with them, and two stop modes. Software issues mode requests from a run mode. A wake event leaves a wait or stop mode. A stop mode always returns to the run mode it was entered from.

The debugger is taken to be present when either of its two power-up requests is high. That indication is sampled only in the run and wait modes and is frozen in the stop modes. If the debugger is present at stop entry, the fast clock stays on so that core registers can still be reached, while debug access to system memory is withdrawn. If the debugger is absent and the debug domain is not retained, the debug logic is treated as powered off and gets a fixed-length reset on wake-up. If the domain is retained, debug resumes on wake-up without any reset.

Top module: `lpm_dbg_ctrl`

## Requirements
- R1: `mode` is one-hot with bit0 full run, bit1 low-power run, bit2 wait, bit3 low-power wait, bit4 stop, bit5 low-power stop. Reset gives full run, `fclk_en` 1, `dbg_mem_en` 0 and `dbg_rst` 0.
- R2: A request is taken only in a run mode, and `mode` changes on the clock edge that samples it. Request codes are 0 full run, 1 low-power run, 2 wait, 3 low-power wait, 4 stop, 5 low-power stop; codes 6 and 7 are unused. Full run accepts 1, 2, 4 and 5. Low-power run accepts 0, 3, 4 and 5. Every other code, and every request outside a run mode, leaves `mode` unchanged.
- R3: `wake` moves wait to full run and low-power wait to low-power run. From either stop mode it returns to the run mode that was active at stop entry. `wake` has no effect in a run mode.
- R4: The debugger counts as active when `dbg_pwrup` or `sys_pwrup` is high. Its held copy follows these inputs on every edge in a run or wait mode and is frozen in a stop mode.
- R5: `fclk_en` is 1 in every mode other than stop. In a stop mode it equals the debugger-active value seen on the edge that accepted the stop request. It changes only on a mode transition.
- R6: `dbg_mem_en` is the held debugger-active value while the mode is not a stop mode, and 0 in both stop modes.
- R7: On a wake from a stop mode that was entered with the debugger inactive and `dbg_retain` low, `dbg_rst` is high for exactly the first two cycles in the restored run mode.
- R8: A wake from a stop mode entered with the debugger active, or with `dbg_retain` high, gives no `dbg_rst` pulse.
- R9: While `dbg_rst` is high, requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Mode request strobe |
| req_code | input | 3 | Requested mode code |
| wake | input | 1 | Wake event for wait and stop modes |
| dbg_pwrup | input | 1 | Debug power-up request |
| sys_pwrup | input | 1 | System power-up request from the debug side |
| dbg_retain | input | 1 | 1: debug domain held static in stop, 0: powered off |
| mode | output | 6 | Current mode, one-hot |
| fclk_en | output | 1 | Core fast clock enable |
| dbg_mem_en | output | 1 | Debug path access to system memory allowed |
| dbg_rst | output | 1 | Reset pulse to the debug logic after power-off recovery |

## Verification
Two events can fall in the same cycle. A mode request can arrive in the first cycle of the recovery reset, just after a wake from a power-off stop. The bench drives such a request in that cycle and expects `mode` to stay in the restored run mode while the pulse runs its full two cycles. The second case is the cycle just after a wake: `dbg_mem_en` must still show the debugger value frozen before the stop, although the power-up inputs changed during the stop, and one cycle later it must show the new inputs. Every combination of entry mode, stop type, both power-up inputs and retention is swept, and the expected values are computed from these rules.

// File: rtl/lpm_dbg_pkg.sv
package lpm_dbg_pkg;
   typedef enum logic [5:0] {
      M_RUN  = 6'b000001,
      M_VLPR = 6'b000010,
      M_WAIT = 6'b000100,
      M_VLPW = 6'b001000,
      M_STOP = 6'b010000,
      M_VLPS = 6'b100000
   } lpm_mode_e;

   localparam logic [2:0] C_RUN  = 3'd0;
   localparam logic [2:0] C_VLPR = 3'd1;
   localparam logic [2:0] C_WAIT = 3'd2;
   localparam logic [2:0] C_VLPW = 3'd3;
   localparam logic [2:0] C_STOP = 3'd4;
   localparam logic [2:0] C_VLPS = 3'd5;

   function automatic logic is_stop(input logic [5:0] m);
      return m[4] | m[5];
   endfunction
endpackage

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
   import lpm_dbg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [2:0] req_code,
   input  logic       wake,
   input  logic       hold_off,
   output lpm_mode_e  mode_q,
   output logic       stop_accept,
   output logic       stop_exit
);
   lpm_mode_e nxt;
   lpm_mode_e ret_q;
   logic      req_ok;

   assign req_ok = req_valid & ~hold_off;

   always_comb begin
      nxt       = mode_q;
      stop_exit = 1'b0;
      unique case (mode_q)
         M_RUN: if (req_ok) begin
            case (req_code)
               C_VLPR:  nxt = M_VLPR;
               C_WAIT:  nxt = M_WAIT;
               C_STOP:  nxt = M_STOP;
               C_VLPS:  nxt = M_VLPS;
               default: nxt = mode_q;
            endcase
         end
         M_VLPR: if (req_ok) begin
            case (req_code)
               C_RUN:   nxt = M_RUN;
               C_VLPW:  nxt = M_VLPW;
               C_STOP:  nxt = M_STOP;
               C_VLPS:  nxt = M_VLPS;
               default: nxt = mode_q;
            endcase
         end
         M_WAIT: if (wake) nxt = M_RUN;
         M_VLPW: if (wake) nxt = M_VLPR;
         M_STOP, M_VLPS: if (wake) begin
            nxt       = ret_q;
            stop_exit = 1'b1;
         end
         default: nxt = M_RUN;
      endcase
   end

   assign stop_accept = is_stop(nxt) & ~is_stop(mode_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_RUN;
         ret_q  <= M_RUN;
      end else begin
         mode_q <= nxt;
         if (stop_accept) ret_q <= mode_q;
      end
   end
endmodule

// File: rtl/lpm_dbg_track.sv
module lpm_dbg_track
   import lpm_dbg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dbg_live,
   input  logic       retain,
   input  logic [5:0] mode_q,
   input  logic       stop_accept,
   input  logic       stop_exit,
   output logic       held_q,
   output logic       fclk_q,
   output logic       pwroff_wake
);
   logic pwroff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q   <= 1'b0;
         fclk_q   <= 1'b1;
         pwroff_q <= 1'b0;
      end else begin
         if (!is_stop(mode_q)) held_q <= dbg_live;
         if (stop_accept) begin
            fclk_q   <= dbg_live;
            pwroff_q <= ~dbg_live & ~retain;
         end else if (stop_exit) begin
            fclk_q   <= 1'b1;
         end
      end
   end

   assign pwroff_wake = stop_exit & pwroff_q;
endmodule

// File: rtl/lpm_rst_pulse.sv
module lpm_rst_pulse #(
   parameter int unsigned PULSE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   localparam int unsigned CW = $clog2(PULSE + 1);
   localparam logic [CW-1:0] LOAD = CW'(PULSE);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (fire)          cnt_q <= LOAD;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign pulse = (cnt_q != '0);
endmodule

// File: rtl/lpm_dbg_ctrl.sv
module lpm_dbg_ctrl
   import lpm_dbg_pkg::*;
#(
   parameter int unsigned RST_CYCLES  = 2,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic [2:0] req_code,
   input  logic       wake,
   input  logic       dbg_pwrup,
   input  logic       sys_pwrup,
   input  logic       dbg_retain,
   output logic [5:0] mode,
   output logic       fclk_en,
   output logic       dbg_mem_en,
   output logic       dbg_rst
);
   if (RST_CYCLES < 1) begin : g_bad_pulse
      $error("RST_CYCLES must be at least 1");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 4 or less");
   end

   logic      raw_act;
   logic      dbg_live;
   lpm_mode_e mode_q;
   logic      stop_accept;
   logic      stop_exit;
   logic      held_q;
   logic      fclk_q;
   logic      pwroff_wake;
   logic      pulse;

   assign raw_act = dbg_pwrup | sys_pwrup;

   if (SYNC_STAGES == 0) begin : g_direct
      assign dbg_live = raw_act;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], raw_act};
      end
      assign dbg_live = sync_q[SYNC_STAGES-1];
   end

   lpm_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_code    (req_code),
      .wake        (wake),
      .hold_off    (pulse),
      .mode_q      (mode_q),
      .stop_accept (stop_accept),
      .stop_exit   (stop_exit)
   );

   lpm_dbg_track u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .dbg_live    (dbg_live),
      .retain      (dbg_retain),
      .mode_q      (mode_q),
      .stop_accept (stop_accept),
      .stop_exit   (stop_exit),
      .held_q      (held_q),
      .fclk_q      (fclk_q),
      .pwroff_wake (pwroff_wake)
   );

   lpm_rst_pulse #(.PULSE(RST_CYCLES)) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (pwroff_wake),
      .pulse (pulse)
   );

   assign mode       = mode_q;
   assign fclk_en    = fclk_q;
   assign dbg_mem_en = held_q & ~is_stop(mode_q);
   assign dbg_rst    = pulse;
endmodule

// File: rtl/lpm_dbg_ctrl_chk.sv
module lpm_dbg_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [5:0] mode,
   input logic       fclk_en,
   input logic       dbg_mem_en,
   input logic       dbg_rst
);
   logic in_stop;
   logic in_run;
   assign in_stop = mode[4] | mode[5];
   assign in_run  = mode[0] | mode[1];

   a_r1_mode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mode) == 1);

   a_r2_change_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode != $past(mode)) && ($past(mode[0]) || $past(mode[1]))) |-> $past(req_valid));

   a_r3_stop_returns_run: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_stop) && !in_stop) |-> in_run);

   a_r5_fclk_on_outside_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !in_stop |-> fclk_en);

   a_r5_fclk_moves_with_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (fclk_en != $past(fclk_en)) |-> (mode != $past(mode)));

   a_r6_no_mem_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
      in_stop |-> !dbg_mem_en);

   a_r7_pulse_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dbg_rst) |-> ##1 dbg_rst ##1 !dbg_rst);

   a_r9_mode_frozen_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_rst |=> $stable(mode));
endmodule

bind lpm_dbg_ctrl lpm_dbg_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .mode       (mode),
   .fclk_en    (fclk_en),
   .dbg_mem_en (dbg_mem_en),
   .dbg_rst    (dbg_rst)
);

// File: tb/lpm_dbg_ctrl_bench.sv
module lpm_dbg_ctrl_bench;
   localparam logic [5:0] B_RUN  = 6'b000001;
   localparam logic [5:0] B_VLPR = 6'b000010;
   localparam logic [5:0] B_WAIT = 6'b000100;
   localparam logic [5:0] B_VLPW = 6'b001000;
   localparam logic [5:0] B_STOP = 6'b010000;
   localparam logic [5:0] B_VLPS = 6'b100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_code = 3'd0;
   logic       wake = 1'b0;
   logic       dbg_pwrup = 1'b0;
   logic       sys_pwrup = 1'b0;
   logic       dbg_retain = 1'b0;
   logic [5:0] mode;
   logic       fclk_en;
   logic       dbg_mem_en;
   logic       dbg_rst;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lpm_dbg_ctrl u_lpm_dbg_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
      .wake(wake), .dbg_pwrup(dbg_pwrup), .sys_pwrup(sys_pwrup),
      .dbg_retain(dbg_retain), .mode(mode), .fclk_en(fclk_en),
      .dbg_mem_en(dbg_mem_en), .dbg_rst(dbg_rst)
   );

   task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic reset_dut();
      rst_n = 1'b0; req_valid = 1'b0; wake = 1'b0;
      cyc(); cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   task automatic request(input logic [2:0] code);
      req_valid = 1'b1; req_code = code;
      cyc();
      req_valid = 1'b0;
   endtask

   function automatic logic [5:0] exp_next(input logic [5:0] src, input logic [2:0] code);
      if (src == B_RUN) begin
         case (code)
            3'd1: return B_VLPR;
            3'd2: return B_WAIT;
            3'd4: return B_STOP;
            3'd5: return B_VLPS;
            default: return src;
         endcase
      end
      case (code)
         3'd0: return B_RUN;
         3'd3: return B_VLPW;
         3'd4: return B_STOP;
         3'd5: return B_VLPS;
         default: return src;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog R1..: act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      reset_dut();
      chk("R1 reset mode", mode, B_RUN);
      chk("R1 reset fclk", {5'd0, fclk_en}, 6'd1);
      chk("R1 reset mem", {5'd0, dbg_mem_en}, 6'd0);
      chk("R1 reset rst", {5'd0, dbg_rst}, 6'd0);

      // R3: wake ignored in run
      wake = 1'b1; cyc(); wake = 1'b0;
      chk("R3 wake in run", mode, B_RUN);

      // R2/R3: transition sweep over both run modes and all codes
      for (int s = 0; s < 2; s++) begin
         for (int c = 0; c < 8; c++) begin
            logic [5:0] src;
            logic [5:0] dst;
            logic [5:0] back;
            src = (s == 0) ? B_RUN : B_VLPR;
            reset_dut();
            if (s == 1) request(3'd1);
            request(3'(c));
            dst = exp_next(src, 3'(c));
            chk("R2 transition", mode, dst);
            if (dst == B_WAIT || dst == B_VLPW) begin
               request(3'd4);
               chk("R2 request in wait ignored", mode, dst);
            end
            wake = 1'b1; cyc(); wake = 1'b0;
            if (dst == B_WAIT)                       back = B_RUN;
            else if (dst == B_VLPW)                  back = B_VLPR;
            else if (dst == B_STOP || dst == B_VLPS) back = src;
            else                                     back = dst;
            chk("R3 wake return", mode, back);
         end
      end

      // R4..R9: sweep entry mode, stop type, power-up inputs, retention
      for (int f = 0; f < 2; f++) begin
         for (int st = 0; st < 2; st++) begin
            for (int v = 0; v < 8; v++) begin
               logic dp, sp, ret, act, off;
               logic [5:0] fm, sm;
               dp = v[0]; sp = v[1]; ret = v[2];
               act = dp | sp;
               off = ~act & ~ret;
               fm = (f == 0) ? B_RUN : B_VLPR;
               sm = (st == 0) ? B_STOP : B_VLPS;
               reset_dut();
               dbg_pwrup = dp; sys_pwrup = sp; dbg_retain = ret;
               if (f == 1) request(3'd1);
               cyc();
               chk("R6 mem in run", {5'd0, dbg_mem_en}, {5'd0, act});
               request((st == 0) ? 3'd4 : 3'd5);
               chk("R2 stop entry", mode, sm);
               chk("R5 fclk in stop", {5'd0, fclk_en}, {5'd0, act});
               chk("R6 mem in stop", {5'd0, dbg_mem_en}, 6'd0);
               dbg_pwrup = ~act; sys_pwrup = 1'b0;
               cyc();
               chk("R4 fclk held in stop", {5'd0, fclk_en}, {5'd0, act});
               chk("R6 mem still off", {5'd0, dbg_mem_en}, 6'd0);
               wake = 1'b1; cyc(); wake = 1'b0;
               chk("R3 stop exit", mode, fm);
               chk("R5 fclk after exit", {5'd0, fclk_en}, 6'd1);
               chk("R4 frozen sample", {5'd0, dbg_mem_en}, {5'd0, act});
               chk(off ? "R7 pulse cycle 1" : "R8 no pulse", {5'd0, dbg_rst}, {5'd0, off});
               if (off) begin
                  request((f == 0) ? 3'd2 : 3'd3);
                  chk("R9 request during pulse", mode, fm);
                  chk("R7 pulse cycle 2", {5'd0, dbg_rst}, 6'd1);
               end else begin
                  cyc();
                  chk("R8 no pulse later", {5'd0, dbg_rst}, 6'd0);
               end
               chk("R4 sample resumes", {5'd0, dbg_mem_en}, {5'd0, ~act});
               cyc();
               chk("R7 pulse ended", {5'd0, dbg_rst}, 6'd0);
            end
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule